// File: doc/BRIEF.md
# Multiplexed Dot-Matrix Row Scanner

This block refreshes a bank of ten characters, each a 5x5 grid of dots, from a 250-bit dot memory. It selects one of the five row lines at a time. For the selected row it drives the column enables of all ten characters at once. One dot-memory word holds the five column bits of one row of one character. A small control word sets the brightness level, lamp test and power-down.

Each row slot is divided into nine scan ticks. The first tick is a dark gap that keeps the columns off while the row lines change. The remaining eight ticks form the dimming window, and brightness level b lights the columns for b+1 of them. A select pin picks where the scan tick comes from: an internal divider of the system clock, or the rising edges of an external clock input that is synchronised into the system clock domain. An asynchronous reset returns the scanner to row 0, clears the dot memory, restores full brightness and holds the display dark until software writes to it.

Top module: `ledmx_scan`

## Requirements
- R1: In the first cycle after reset is released, `row_sel` equals 5'b00001 (bit r selects row r) and `col_en` is all zero.
- R2: After reset, `col_en` stays all zero while the rows keep scanning. This holds until a dot-memory write or a control-word write is accepted.
- R3: Exactly one `row_sel` bit is set while not powered down. The rows advance 0,1,2,3,4,0 and each row lasts exactly 9 scan ticks.
- R4: A write stores `wr_data` at `wr_addr` = character*5 + row, and bit k of the word is column k. While row r is selected and the columns are lit, `col_en[c*5+k]` equals bit k of the word at address c*5+r.
- R5: The control word's 3-bit level b (0 to 7) lights the columns for b+1 scan ticks per row, on ticks 1 to b+1 of the slot. Level 7 therefore lights them for 8 ticks.
- R6: During the first scan tick of every row slot, `col_en` is all zero.
- R7: When lamp test is set, every `col_en` bit is on during the lit ticks. The dot memory contents and the blank-after-reset state have no effect, and the selected level still applies.
- R8: When power-down is set, `row_sel` and `col_en` are all zero and the scan position is frozen. On clearing power-down, scanning resumes on the same row.
- R9: With `clk_sel` = 1, a scan tick occurs every DIV system clocks and `ext_clk` has no effect. With `clk_sel` = 0, one scan tick occurs per rising edge of `ext_clk`.
- R10: Asserting `rst_n` low at once forces row 0 with all columns dark. Reset also clears the dot memory, sets the level to 7 and clears lamp test and power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_sel | input | 1 | Scan tick source: 1 internal divider, 0 external clock |
| ext_clk | input | 1 | External scan clock, asynchronous |
| wr_en | input | 1 | Dot-memory write strobe |
| wr_addr | input | 6 | Dot-memory word address, character*5 + row |
| wr_data | input | 5 | Column bits of one character row |
| ctrl_we | input | 1 | Control-word write strobe |
| ctrl_level | input | 3 | Brightness level, 7 = full |
| ctrl_lamp | input | 1 | Lamp test enable |
| ctrl_pdown | input | 1 | Power-down enable |
| row_sel | output | 5 | One-hot row line drive |
| col_en | output | 50 | Column enables, bit c*5+k = character c column k |

## Verification
The scanner is checked with random dot patterns in all fifty rows and with a single lit row after a mid-run reset. These two patterns show whether each row reads its own memory word and whether the memory really clears. Brightness is swept over directed level 0 and random levels under both tick sources. The lit-tick count per row tells the dimming window apart from the tick period, and a fast-toggling external clock during internal mode shows that the unselected source is ignored. Lamp test at a reduced level and power-down entered at a known row check the override and the frozen scan position.

// File: rtl/ledmx_pkg.sv
package ledmx_pkg;
   localparam int LVL_W     = 3;
   localparam int N_LEVELS  = 1 << LVL_W;
   localparam int SUB_SLOTS = N_LEVELS + 1;
   localparam int SUB_W     = $clog2(SUB_SLOTS);

   typedef logic [LVL_W-1:0] level_t;
   typedef logic [SUB_W-1:0] sub_t;

   typedef struct packed {
      level_t level;
      logic   lamp;
      logic   pdown;
   } ctrl_t;

   localparam level_t LEVEL_FULL = level_t'(N_LEVELS - 1);
   localparam sub_t   SUB_LAST   = sub_t'(SUB_SLOTS - 1);

   typedef enum logic {
      SRC_EXT = 1'b0,
      SRC_INT = 1'b1
   } clk_src_e;
endpackage

// File: rtl/ledmx_tick_gen.sv
module ledmx_tick_gen
   import ledmx_pkg::*;
#(
   parameter int DIV         = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_clk,
   input  logic clk_sel,
   output logic tick
);
   localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

   if (DIV < 1) begin : g_bad_div
      $error("ledmx_tick_gen: DIV must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ledmx_tick_gen: SYNC_STAGES must be at least 2");
   end

   // synchroniser plus one history stage for edge detection
   logic [SYNC_STAGES:0] sync_q;
   logic                 ext_rise;
   logic                 int_tick;
   clk_src_e             src;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk};
   end

   assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

   if (DIV == 1) begin : g_div_pass
      assign int_tick = 1'b1;
   end else begin : g_div_cnt
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         div_q <= '0;
         else if (div_q == DIV_W'(DIV - 1))  div_q <= '0;
         else                                div_q <= div_q + 1'b1;
      end
      assign int_tick = (div_q == DIV_W'(DIV - 1));
   end

   assign src  = clk_src_e'(clk_sel);
   assign tick = (src == SRC_INT) ? int_tick : ext_rise;
endmodule

// File: rtl/ledmx_scan_ctr.sv
module ledmx_scan_ctr
   import ledmx_pkg::*;
#(
   parameter int N_ROWS = 5,
   parameter int ROW_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             hold,
   output sub_t             sub_q,
   output logic [ROW_W-1:0] row_q
);
   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(N_ROWS - 1);

   if (N_ROWS < 2) begin : g_bad_rows
      $error("ledmx_scan_ctr: N_ROWS must be at least 2");
   end

   logic advance;
   logic slot_end;

   assign advance  = tick && !hold;
   assign slot_end = (sub_q == SUB_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q <= '0;
         row_q <= '0;
      end else if (advance) begin
         if (slot_end) begin
            sub_q <= '0;
            row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
         end else begin
            sub_q <= sub_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ledmx_dot_mem.sv
module ledmx_dot_mem #(
   parameter int N_CHARS = 10,
   parameter int N_ROWS  = 5,
   parameter int N_COLS  = 5,
   parameter int ADDR_W  = 6,
   parameter int ROW_W   = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [N_COLS-1:0]         wr_data,
   input  logic [ROW_W-1:0]          rd_row,
   output logic [N_CHARS*N_COLS-1:0] rd_bits,
   output logic                      wr_ok
);
   localparam int DEPTH = N_CHARS * N_ROWS;

   if ((1 << ADDR_W) < DEPTH) begin : g_bad_addr
      $error("ledmx_dot_mem: ADDR_W too narrow for the dot memory");
   end

   logic [N_COLS-1:0] mem_q [DEPTH];

   assign wr_ok = wr_en && (int'(wr_addr) < DEPTH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (wr_ok) begin
         mem_q[wr_addr] <= wr_data;
      end
   end

   // one read port per character, all addressed by the current row
   for (genvar c = 0; c < N_CHARS; c++) begin : g_rd
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(c * N_ROWS);
      logic [ADDR_W-1:0] rd_idx;
      assign rd_idx = BASE + ADDR_W'(rd_row);
      assign rd_bits[c*N_COLS +: N_COLS] = mem_q[rd_idx];
   end
endmodule

// File: rtl/ledmx_col_gate.sv
module ledmx_col_gate
   import ledmx_pkg::*;
#(
   parameter int N_CHARS = 10,
   parameter int N_ROWS  = 5,
   parameter int N_COLS  = 5,
   parameter int ROW_W   = 3
) (
   input  sub_t                      sub_q,
   input  logic [ROW_W-1:0]          row_q,
   input  ctrl_t                     ctrl,
   input  logic                      blank,
   input  logic [N_CHARS*N_COLS-1:0] rd_bits,
   output logic [N_ROWS-1:0]         row_sel,
   output logic [N_CHARS*N_COLS-1:0] col_en
);
   sub_t on_last;
   logic in_window;
   logic slot_on;

   // tick 0 is the dark gap; ticks 1..level+1 are lit
   assign on_last   = sub_t'(ctrl.level) + sub_t'(1);
   assign in_window = (sub_q != '0) && (sub_q <= on_last);
   assign slot_on   = in_window && !ctrl.pdown && (ctrl.lamp || !blank);

   for (genvar c = 0; c < N_CHARS; c++) begin : g_char
      for (genvar k = 0; k < N_COLS; k++) begin : g_col
         assign col_en[c*N_COLS+k] = slot_on && (ctrl.lamp || rd_bits[c*N_COLS+k]);
      end
   end

   for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      assign row_sel[r] = !ctrl.pdown && (row_q == ROW_W'(r));
   end
endmodule

// File: rtl/ledmx_scan.sv
module ledmx_scan
   import ledmx_pkg::*;
#(
   parameter int  N_CHARS     = 10,
   parameter int  N_ROWS      = 5,
   parameter int  N_COLS      = 5,
   parameter int  DIV         = 4,
   parameter int  SYNC_STAGES = 2,
   localparam int ADDR_W      = $clog2(N_CHARS * N_ROWS),
   localparam int ROW_W       = $clog2(N_ROWS),
   localparam int COL_W       = N_CHARS * N_COLS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_sel,
   input  logic              ext_clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [N_COLS-1:0] wr_data,
   input  logic              ctrl_we,
   input  logic [LVL_W-1:0]  ctrl_level,
   input  logic              ctrl_lamp,
   input  logic              ctrl_pdown,
   output logic [N_ROWS-1:0] row_sel,
   output logic [COL_W-1:0]  col_en
);
   if (N_CHARS < 1 || N_COLS < 1) begin : g_bad_shape
      $error("ledmx_scan: N_CHARS and N_COLS must be positive");
   end

   logic             scan_tick;
   sub_t             sub_q;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] rd_bits;
   logic             wr_ok;
   ctrl_t            ctrl_q;
   logic             blank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '{level: LEVEL_FULL, lamp: 1'b0, pdown: 1'b0};
      end else if (ctrl_we) begin
         ctrl_q <= '{level: ctrl_level, lamp: ctrl_lamp, pdown: ctrl_pdown};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                blank_q <= 1'b1;
      else if (wr_ok || ctrl_we) blank_q <= 1'b0;
   end

   ledmx_tick_gen #(
      .DIV         (DIV),
      .SYNC_STAGES (SYNC_STAGES)
   ) tick_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .ext_clk (ext_clk),
      .clk_sel (clk_sel),
      .tick    (scan_tick)
   );

   ledmx_scan_ctr #(
      .N_ROWS (N_ROWS),
      .ROW_W  (ROW_W)
   ) ctr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (scan_tick),
      .hold  (ctrl_q.pdown),
      .sub_q (sub_q),
      .row_q (row_q)
   );

   ledmx_dot_mem #(
      .N_CHARS (N_CHARS),
      .N_ROWS  (N_ROWS),
      .N_COLS  (N_COLS),
      .ADDR_W  (ADDR_W),
      .ROW_W   (ROW_W)
   ) mem_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_row  (row_q),
      .rd_bits (rd_bits),
      .wr_ok   (wr_ok)
   );

   ledmx_col_gate #(
      .N_CHARS (N_CHARS),
      .N_ROWS  (N_ROWS),
      .N_COLS  (N_COLS),
      .ROW_W   (ROW_W)
   ) gate_i (
      .sub_q   (sub_q),
      .row_q   (row_q),
      .ctrl    (ctrl_q),
      .blank   (blank_q),
      .rd_bits (rd_bits),
      .row_sel (row_sel),
      .col_en  (col_en)
   );
endmodule

// File: rtl/ledmx_scan_chk.sv
module ledmx_scan_chk
   import ledmx_pkg::*;
#(
   parameter int N_ROWS = 5,
   parameter int ROW_W  = 3,
   parameter int WIDTH  = 50
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scan_tick,
   input ctrl_t             ctrl_q,
   input sub_t              sub_q,
   input logic [ROW_W-1:0]  row_q,
   input logic [N_ROWS-1:0] row_sel,
   input logic [WIDTH-1:0]  col_en
);
   assert_row_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.pdown |-> $countones(row_sel) == 1);

   assert_row_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(row_q) < N_ROWS);

   assert_row_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_tick |=> $stable(row_q));

   assert_gap_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_q == '0) |-> (col_en == '0));

   assert_level_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_q > sub_t'(ctrl_q.level) + sub_t'(1)) |-> (col_en == '0));

   assert_pdown_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.pdown |-> (row_sel == '0 && col_en == '0));

   assert_pdown_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.pdown && $past(ctrl_q.pdown)) |-> ($stable(row_q) && $stable(sub_q)));
endmodule

bind ledmx_scan ledmx_scan_chk #(
   .N_ROWS (N_ROWS),
   .ROW_W  (ROW_W),
   .WIDTH  (COL_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .scan_tick (scan_tick),
   .ctrl_q    (ctrl_q),
   .sub_q     (sub_q),
   .row_q     (row_q),
   .row_sel   (row_sel),
   .col_en    (col_en)
);

// File: tb/ledmx_scan_tb.sv
module ledmx_scan_tb_top;
   localparam int NC  = 10;
   localparam int NR  = 5;
   localparam int NK  = 5;
   localparam int DIV = 4;
   localparam int EXT_HALF = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_sel = 1'b1;
   logic          ext_clk = 1'b0;
   logic          wr_en = 1'b0;
   logic [5:0]    wr_addr = '0;
   logic [4:0]    wr_data = '0;
   logic          ctrl_we = 1'b0;
   logic [2:0]    ctrl_level = 3'd7;
   logic          ctrl_lamp = 1'b0;
   logic          ctrl_pdown = 1'b0;
   logic [NR-1:0] row_sel;
   logic [NC*NK-1:0] col_en;

   int checks = 0;
   int failures = 0;
   int ext_half = 1;
   int last_row = -1;
   bit done = 0;
   logic [NK-1:0] shadow [NC*NR];

   always #2 clk = ~clk;

   ledmx_scan dut_i (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_clk(ext_clk),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ctrl_we(ctrl_we), .ctrl_level(ctrl_level), .ctrl_lamp(ctrl_lamp),
      .ctrl_pdown(ctrl_pdown), .row_sel(row_sel), .col_en(col_en)
   );

   initial begin
      forever begin
         repeat (ext_half) @(negedge clk);
         ext_clk = ~ext_clk;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint unsigned act, input longint unsigned exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   function automatic logic [NC*NK-1:0] exp_cols(input int r, input bit lamp);
      logic [NC*NK-1:0] v;
      for (int c = 0; c < NC; c++)
         for (int k = 0; k < NK; k++)
            v[c*NK+k] = lamp ? 1'b1 : shadow[c*NR+r][k];
      return v;
   endfunction

   task automatic clear_shadow();
      for (int i = 0; i < NC*NR; i++) shadow[i] = '0;
   endtask

   task automatic write_row(input int c, input int r, input logic [NK-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 6'(c*NR + r); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      shadow[c*NR + r] = d;
   endtask

   task automatic write_ctrl(input int lvl, input bit lamp, input bit pd);
      @(negedge clk);
      ctrl_we = 1'b1; ctrl_level = 3'(lvl); ctrl_lamp = lamp; ctrl_pdown = pd;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic sync_row();
      logic [NR-1:0] s;
      s = row_sel;
      do @(negedge clk); while (row_sel == s);
      last_row = -1;
   endtask

   // starts on the first sample of a row slot, ends on the first sample of the next
   task automatic measure_row(input int p, input int lvl, input bit lamp,
                              input bit blanked, input string req);
      logic [NR-1:0]    start_row;
      logic [NC*NK-1:0] pat;
      int idx = 0;
      int onc = 0;
      int exp_on;
      bit lead_bad = 0;
      bit pat_bad = 0;
      logic [NC*NK-1:0] bad_val = '0;
      start_row = row_sel;
      for (int r = 0; r < NR; r++) if (row_sel[r]) idx = r;
      chk($countones(row_sel) == 1, "R3", "row one-hot", row_sel, 0);
      if (last_row >= 0)
         chk(idx == (last_row + 1) % NR, "R3", "row order", idx, (last_row + 1) % NR);
      pat = (blanked && !lamp) ? '0 : exp_cols(idx, lamp);
      for (int i = 0; i < 9*p; i++) begin
         if (col_en != '0) begin
            onc++;
            if (i < p) lead_bad = 1;
            if (col_en != pat) begin pat_bad = 1; bad_val = col_en; end
         end
         @(negedge clk);
      end
      chk(row_sel != start_row, "R3", "row slot length", row_sel, 0);
      chk(!lead_bad, "R6", "dark first tick", lead_bad, 0);
      chk(!pat_bad, req, "column pattern", bad_val, pat);
      exp_on = (pat == '0) ? 0 : (lvl + 1) * p;
      chk(onc == exp_on, (pat == '0) ? req : "R5", "lit cycles", onc, exp_on);
      last_row = idx;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(0, "WATCHDOG", "run timed out", 0, 1);
      finish_run();
   end

   initial begin
      int unsigned seed;
      int lvl;
      logic [NR-1:0] rec;
      bit pd_ok;
      seed = 32'h1d5ca7;
      void'($urandom(seed));
      clear_shadow();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(row_sel == 5'b00001, "R1", "row after reset", row_sel, 1);
      chk(col_en == '0, "R1", "columns after reset", col_en, 0);

      // R2: blanked frame while scanning continues
      sync_row();
      for (int r = 0; r < NR; r++) measure_row(DIV, 7, 0, 1, "R2");

      // R4 with random dots at full level (R9 internal, ext toggling fast)
      for (int a = 0; a < NC*NR; a++) write_row(a / NR, a % NR, 5'($urandom));
      sync_row();
      for (int r = 0; r < NR; r++) measure_row(DIV, 7, 0, 0, "R4");

      // R5 levels: directed 0 then random, R9 internal source with ext ignored
      for (int it = 0; it < 5; it++) begin
         lvl = (it == 0) ? 0 : int'($urandom % 8);
         if (it == 2)
            for (int a = 0; a < NC*NR; a++) write_row(a / NR, a % NR, 5'($urandom));
         write_ctrl(lvl, 0, 0);
         sync_row();
         measure_row(DIV, lvl, 0, 0, "R9");
         measure_row(DIV, lvl, 0, 0, "R5");
      end

      // R7 lamp test at reduced level
      write_ctrl(2, 1, 0);
      sync_row();
      for (int r = 0; r < NR; r++) measure_row(DIV, 2, 1, 0, "R7");

      // R9 external source
      write_ctrl(5, 0, 0);
      ext_half = EXT_HALF;
      @(negedge clk);
      clk_sel = 1'b0;
      sync_row();
      sync_row();
      for (int r = 0; r < 3; r++) measure_row(2*EXT_HALF, 5, 0, 0, "R9");
      clk_sel = 1'b1;
      ext_half = 1;

      // R8 power-down freezes at a known row
      sync_row();
      sync_row();
      rec = row_sel;
      write_ctrl(7, 0, 1);
      pd_ok = 1;
      for (int i = 0; i < 60; i++) begin
         if (row_sel != '0 || col_en != '0) pd_ok = 0;
         @(negedge clk);
      end
      chk(pd_ok, "R8", "dark in power-down", row_sel, 0);
      write_ctrl(2, 0, 0);
      chk(row_sel == rec, "R8", "resume row", row_sel, rec);

      // R10 asynchronous reset mid-run
      sync_row();
      repeat (DIV*3) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(row_sel == 5'b00001, "R10", "row during reset", row_sel, 1);
      chk(col_en == '0, "R10", "columns during reset", col_en, 0);
      clear_shadow();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      write_row(3, 2, 5'b10101);
      sync_row();
      for (int r = 0; r < NR; r++) measure_row(DIV, 7, 0, 0, "R10");

      finish_run();
   end
endmodule